// File: doc/BRIEF.md
# Chained Retriggerable Watchdog Counter Bank

This block holds a small bank of 64-bit down-counters behind a 32-bit register port. Each counter has its own settings: an enable, a mode, a trigger source and a clock prescaler. Its count is written and read as two 32-bit words. When a running counter reaches zero it emits a one-cycle end pulse. A counter in hardware-signal mode can listen to the end pulse of the counter below it. That pulse reloads it and starts it again.

The intended use pairs two neighbours. The upper counter is the watchdog: it runs in hardware-signal mode and listens to the counter below. The lower counter is a one-shot with a count of zero. To keep the watchdog alive, software disables and re-enables the one-shot. The one-shot then fires at once and restarts the watchdog from its reload value, so the watchdog itself is never stopped. A select register marks which counters may raise the watchdog reset output. A read of a low count word snapshots the matching high word, so a 64-bit value can be read in two accesses without tearing.

Top module: `wdt_chain_bank`

## Requirements
- R1: A control word at offset n*0x10 reads back as {16'h0, prescaler[15:8], trigger[7:4], mode[3:2], running[1], enable[0]}. Bit 1 reflects counter state and ignores writes, and bits 31:16 read as zero. Read data appears on `bus_rdata` one cycle after the read strobe.
- R2: A write to the low word (n*0x10+0x4) or the high word (n*0x10+0x8) loads both the reload value and the current value of that half. Reads of the low word return the current low half.
- R3: Reading a low word stores that counter's current high half in a holding register. A later read of the high word returns the holding register, not the live high half.
- R4: A one-shot counter (mode 2'b00) that is enabled by a 0-to-1 write of bit 0 reloads its current value from its reload value and starts running. If that value is zero, its end pulse appears in the cycle after the one in which the enable write is taken.
- R5: A running counter steps down by one every P clocks, where P is the prescaler field (0 and 1 both mean every clock). For a reload value N it pulses end count N*P+1 cycles after the enabling write.
- R6: The end pulse lasts one cycle, and the running flag is clear from that cycle on.
- R7: A counter in mode 2'b11 stays idle when enabled. With trigger code 4'h5, each end pulse of the counter below reloads it and starts it one cycle later, including while it is already counting.
- R8: Counter 0 has no counter below it and is never triggered. Trigger codes other than 4'h5 never start a counter.
- R9: Writing enable 0 stops the counter, clears its running flag and freezes its current value. A later enable of a one-shot counter reloads the stored reload value, and gives a fresh end pulse when that value is zero.
- R10: The select register at offset 0x40 has one bit per counter. An end pulse of a selected counter sets `wdog_rst_o` in the following cycle, and it stays set until reset. End pulses of unselected counters leave it low.
- R11: Reset clears every control field, count value, holding register and select bit, and drives `wdog_rst_o` and all end pulses low.
- R12: The select register reads back its four bits in bits 3:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wdog_rst_o | output | 1 | Sticky watchdog reset request |
| end_pulse_o | output | 4 | One-cycle end-count pulse per counter |

## Verification
The assertions assume that a read and a write are never requested in the same cycle, and that reset is held from the first clock. They also assume that a high-word read only means a coherent value when a low-word read of the same counter came just before it. The stimulus meets these assumptions by driving each access from a task that raises exactly one strobe for one cycle on the falling edge. Reset is asserted at time zero. Random control and count values go only to disabled counters with an empty select register, so no random pattern can start a chain or set the reset output. The timed scenarios then enable counters on purpose.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W   = 32;
    localparam int PRESC_W  = 8;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_LOW   = 4'h4;
    localparam logic [3:0] OFS_HIGH  = 4'h8;

    localparam logic [1:0] MODE_ONESHOT = 2'b00;
    localparam logic [1:0] MODE_HW      = 2'b11;
    localparam logic [3:0] TRIG_PREV    = 4'h5;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [3:0]         trig;
        logic [1:0]         mode;
        logic               en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_LOW,
        ACC_HIGH,
        ACC_SEL
    } acc_kind_t;

    function automatic ctrl_t ctrl_from_word(logic [15:0] w);
        ctrl_t c;
        c.presc = w[15:8];
        c.trig  = w[7:4];
        c.mode  = w[3:2];
        c.en    = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c, logic running);
        return {16'h0, c.presc, c.trig, c.mode, running, c.en};
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = (div == '0) ? PW'(0) : div - PW'(1);
        tick  = run && (pcnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= tick ? '0 : pcnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctrl,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    input  logic            prev_end,
    output ctrl_t           cfg_o,
    output logic            active_o,
    output logic [2*DW-1:0] cur_o,
    output logic            end_o
);
    localparam int CW = 2 * DW;

    ctrl_t          cfg_q, cfg_d, new_cfg;
    logic           active_q, active_d;
    logic           end_q;
    logic [CW-1:0]  init_q, init_d, cur_q, cur_d;
    logic           start, stop, trig_fire, at_zero, end_d, count_en, tick;

    always_comb begin
        new_cfg   = ctrl_from_word(wdata[15:0]);
        start     = wr_ctrl && new_cfg.en && !cfg_q.en;
        stop      = wr_ctrl && !new_cfg.en;
        trig_fire = !wr_ctrl && cfg_q.en && (cfg_q.mode == MODE_HW)
                    && (cfg_q.trig == TRIG_PREV) && prev_end;
        at_zero   = (cur_q == '0);
        end_d     = !wr_ctrl && !trig_fire && active_q && at_zero;
        count_en  = !wr_ctrl && !trig_fire && active_q && !at_zero;
    end

    wdt_prescale #(.PW(PRESC_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (start || trig_fire),
        .run   (count_en),
        .div   (cfg_q.presc),
        .tick  (tick)
    );

    always_comb begin
        cfg_d    = wr_ctrl ? new_cfg : cfg_q;
        active_d = active_q;
        cur_d    = cur_q;
        init_d   = init_q;
        if (start) begin
            active_d = (new_cfg.mode != MODE_HW);
            if (new_cfg.mode != MODE_HW) cur_d = init_q;
        end else if (stop) begin
            active_d = 1'b0;
        end else if (trig_fire) begin
            active_d = 1'b1;
            cur_d    = init_q;
        end else if (end_d) begin
            active_d = 1'b0;
        end else if (count_en && tick) begin
            cur_d = cur_q - CW'(1);
        end
        if (wr_lo) begin
            init_d[DW-1:0] = wdata;
            cur_d[DW-1:0]  = wdata;
        end
        if (wr_hi) begin
            init_d[CW-1:DW] = wdata;
            cur_d[CW-1:DW]  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            active_q <= 1'b0;
            end_q    <= 1'b0;
            init_q   <= '0;
            cur_q    <= '0;
        end else begin
            cfg_q    <= cfg_d;
            active_q <= active_d;
            end_q    <= end_d;
            init_q   <= init_d;
            cur_q    <= cur_d;
        end
    end

    assign cfg_o    = cfg_q;
    assign active_o = active_q;
    assign cur_o    = cur_q;
    assign end_o    = end_q;

    // R6: end pulse is a single cycle wide
    p_end_single_r6: assert property (@(posedge clk) disable iff (rst)
        end_q |=> !end_q);

    // R6: the running flag is already clear while the end pulse is high
    p_end_idle_r6: assert property (@(posedge clk) disable iff (rst)
        end_q |-> !active_q);

    // R9: an idle counter keeps its value unless written or started
    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !wr_lo && !wr_hi && !start && !trig_fire) |=> $stable(cur_q));

    // R5: a running counter only holds or steps down by one
    p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
        (count_en && !wr_lo && !wr_hi) |=>
            ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - CW'(1))));

    // R7: running only begins from an enable write or a trigger
    p_start_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> ($past(start) || $past(trig_fire)));
endmodule

// File: rtl/wdt_readback.sv
module wdt_readback
    import wdt_pkg::*;
#(
    parameter int NC = 4,
    parameter int IW = 2,
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  acc_kind_t                kind,
    input  logic [IW-1:0]            idx,
    input  logic [NC-1:0][DW-1:0]    ctrl_words,
    input  logic [NC-1:0][2*DW-1:0]  cur_vals,
    input  logic [NC-1:0]            sel,
    output logic [DW-1:0]            rdata
);
    logic [NC-1:0][DW-1:0] hold_q;
    logic [DW-1:0]         cur_hi_sel;

    assign cur_hi_sel = cur_vals[idx][2*DW-1:DW];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            hold_q <= '0;
        end else if (rd_en) begin
            unique case (kind)
                ACC_CTRL: rdata <= ctrl_words[idx];
                ACC_LOW: begin
                    rdata       <= cur_vals[idx][DW-1:0];
                    hold_q[idx] <= cur_hi_sel;
                end
                ACC_HIGH: rdata <= hold_q[idx];
                ACC_SEL:  rdata <= {{(DW-NC){1'b0}}, sel};
                default:  rdata <= '0;
            endcase
        end
    end

    // R3: a high read right after a low read of the same counter returns the snapshot
    p_coherent_high_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && kind == ACC_LOW) ##1 (rd_en && kind == ACC_HIGH && idx == $past(idx))
            |=> (rdata == $past(cur_hi_sel, 2)));
endmodule

// File: rtl/wdt_chain_bank.sv
module wdt_chain_bank
    import wdt_pkg::*;
#(
    parameter int N_CNT  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdog_rst_o,
    output logic [N_CNT-1:0]  end_pulse_o
);
    localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(N_CNT * 16);

    acc_kind_t                    acc_kind;
    logic [IDX_W-1:0]             acc_idx;
    logic [N_CNT-1:0][DATA_W-1:0] ctrl_words;
    logic [N_CNT-1:0][2*DATA_W-1:0] cur_vals;
    logic [N_CNT-1:0]             end_vec;
    logic [N_CNT-1:0]             sel_q;
    logic                         wdog_q;

    always_comb begin
        acc_idx  = bus_addr[IDX_W+3:4];
        acc_kind = ACC_NONE;
        if (int'(bus_addr[ADDR_W-1:4]) < N_CNT) begin
            case (bus_addr[3:0])
                OFS_CTRL: acc_kind = ACC_CTRL;
                OFS_LOW:  acc_kind = ACC_LOW;
                OFS_HIGH: acc_kind = ACC_HIGH;
                default:  acc_kind = ACC_NONE;
            endcase
        end else if (bus_addr == SEL_ADDR) begin
            acc_kind = ACC_SEL;
        end
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        ctrl_t cfg;
        logic  active;
        logic  hit;
        logic  prev_end;

        assign hit = bus_wr && (acc_idx == IDX_W'(i));

        if (i == 0) begin : g_head
            assign prev_end = 1'b0;
        end else begin : g_link
            assign prev_end = end_vec[i-1];
        end

        wdt_counter #(.DW(DATA_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (hit && acc_kind == ACC_CTRL),
            .wr_lo    (hit && acc_kind == ACC_LOW),
            .wr_hi    (hit && acc_kind == ACC_HIGH),
            .wdata    (bus_wdata),
            .prev_end (prev_end),
            .cfg_o    (cfg),
            .active_o (active),
            .cur_o    (cur_vals[i]),
            .end_o    (end_vec[i])
        );

        assign ctrl_words[i] = ctrl_word(cfg, active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            wdog_q <= 1'b0;
        end else begin
            if (bus_wr && acc_kind == ACC_SEL) sel_q <= bus_wdata[N_CNT-1:0];
            wdog_q <= wdog_q | (|(end_vec & sel_q));
        end
    end

    wdt_readback #(.NC(N_CNT), .IW(IDX_W), .DW(DATA_W)) u_rb (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (bus_rd),
        .kind       (acc_kind),
        .idx        (acc_idx),
        .ctrl_words (ctrl_words),
        .cur_vals   (cur_vals),
        .sel        (sel_q),
        .rdata      (bus_rdata)
    );

    assign wdog_rst_o  = wdog_q;
    assign end_pulse_o = end_vec;

    // R10: once raised, the watchdog request holds until reset
    p_wdog_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        wdog_q |=> wdog_q);

    // R10: the request only rises after an end pulse of a selected counter
    p_wdog_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_q) |-> $past(|(end_vec & sel_q)));

    // R8: the bottom counter never sees a trigger from below
    p_head_no_trig_r8: assert property (@(posedge clk) disable iff (rst)
        (!g_cnt[0].active && g_cnt[0].cfg.mode == MODE_HW && !bus_wr) |=> !g_cnt[0].active);
endmodule

// File: tb/wdt_chain_bank_tb.sv
module wdt_chain_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_o;
    logic [3:0]  end_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_chain_bank u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdog_rst_o  (wdog_rst_o),
        .end_pulse_o (end_pulse_o)
    );

    function automatic logic [7:0] a_ctl(int i); return 8'(i * 16);     endfunction
    function automatic logic [7:0] a_lo(int i);  return 8'(i * 16 + 4); endfunction
    function automatic logic [7:0] a_hi(int i);  return 8'(i * 16 + 8); endfunction
    localparam logic [7:0] A_SEL = 8'h40;

    function automatic logic [31:0] exp_ctrl(logic [31:0] w, logic running);
        return {16'h0, w[15:2], running, w[0]};
    endfunction

    function automatic int exp_delay(int n, int p);
        return n * ((p == 0) ? 1 : p) + 1;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic wait_end(int i, int limit, output int got);
        got = -1;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (end_pulse_o[i]) begin
                got = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2, w;
        int got, seed;
        seed = $urandom(32'd4711);
        idle(3);
        rst = 1'b0;

        // R11: reset state
        check("R11 wdog", {63'h0, wdog_rst_o}, 64'h0);
        check("R11 end", {60'h0, end_pulse_o}, 64'h0);
        for (int i = 0; i < 4; i++) begin
            rd(a_ctl(i), d); check("R11 ctrl", {32'h0, d}, 64'h0);
            rd(a_lo(i), d);  check("R11 low", {32'h0, d}, 64'h0);
            rd(a_hi(i), d);  check("R11 high", {32'h0, d}, 64'h0);
        end
        rd(A_SEL, d); check("R11 sel", {32'h0, d}, 64'h0);

        // R1: directed control readback, bit 1 and upper bits ignored
        wr(a_ctl(0), 32'hFFFF_03F6);
        rd(a_ctl(0), d);
        check("R1 ctrl fields", {32'h0, d}, 64'h0000_03F4);

        // R1 / R2: random patterns on disabled counters
        for (int it = 0; it < 16; it++) begin
            int i = $urandom % 4;
            w = $urandom & 32'hFFFF_FFFE;
            wr(a_ctl(i), w);
            rd(a_ctl(i), d);
            check("R1 random ctrl", {32'h0, d}, {32'h0, exp_ctrl(w, 1'b0)});
            w = $urandom;
            wr(a_lo(i), w);
            d2 = $urandom;
            wr(a_hi(i), d2);
            rd(a_lo(i), d);
            check("R2 low word", {32'h0, d}, {32'h0, w});
            rd(a_hi(i), d);
            check("R2 high word", {32'h0, d}, {32'h0, d2});
        end

        // R12: select register readback
        wr(A_SEL, 32'hFFFF_FFF5);
        rd(A_SEL, d);
        check("R12 select", {32'h0, d}, 64'h5);
        wr(A_SEL, 32'h0);

        // R4: one-shot at zero fires the cycle after the enable write
        wr(a_ctl(2), 0); wr(a_lo(2), 0); wr(a_hi(2), 0);
        wr(a_ctl(2), 32'h1);
        check("R4 no pulse yet", {63'h0, end_pulse_o[2]}, 64'h0);
        @(negedge clk);
        check("R4 immediate pulse", {63'h0, end_pulse_o[2]}, 64'h1);
        @(negedge clk);
        check("R6 single cycle", {63'h0, end_pulse_o[2]}, 64'h0);
        rd(a_ctl(2), d);
        check("R6 running cleared", {32'h0, d}, 64'h1);

        // R9: disable then enable at zero gives a fresh pulse
        wr(a_ctl(2), 0);
        wr(a_ctl(2), 32'h1);
        @(negedge clk);
        check("R9 fresh pulse", {63'h0, end_pulse_o[2]}, 64'h1);

        // R5: random reload values and prescalers
        for (int it = 0; it < 10; it++) begin
            int i = $urandom % 4;
            int n = 1 + ($urandom % 12);
            int p = $urandom % 5;
            wr(a_ctl(i), 0);
            wr(a_lo(i), 32'(n));
            wr(a_hi(i), 0);
            wr(a_ctl(i), 32'(p << 8) | 32'h1);
            wait_end(i, 200, got);
            check("R5 end delay", 64'(got), 64'(exp_delay(n, p)));
        end
        check("R10 unselected no reset", {63'h0, wdog_rst_o}, 64'h0);

        // R3: coherent 64-bit read across a borrow
        wr(a_ctl(3), 0); wr(a_lo(3), 32'h3); wr(a_hi(3), 32'h1);
        wr(a_ctl(3), 32'h101);
        idle(3);
        rd(a_lo(3), d);
        rd(a_hi(3), d2);
        check("R3 low at snapshot", {32'h0, d}, 64'h0);
        check("R3 high from snapshot", {32'h0, d2}, 64'h1);
        wr(a_ctl(3), 0);

        // R9: disable freezes the value, re-enable reloads
        wr(a_ctl(1), 0); wr(a_lo(1), 32'd50); wr(a_hi(1), 0);
        wr(a_ctl(1), 32'h101);
        idle(5);
        wr(a_ctl(1), 32'h100);
        rd(a_lo(1), d);
        check("R9 frozen value", {32'h0, d}, 64'd45);
        idle(10);
        rd(a_lo(1), d);
        check("R9 still frozen", {32'h0, d}, 64'd45);
        rd(a_ctl(1), d);
        check("R9 running clear", {32'h0, d}, 64'h100);
        wr(a_ctl(1), 32'h101);
        wait_end(1, 200, got);
        check("R9 reload on enable", 64'(got), 64'(exp_delay(50, 1)));

        // R8: counter 0 in hardware mode has no trigger source
        wr(a_ctl(0), 0); wr(a_lo(0), 32'd3); wr(a_hi(0), 0);
        wr(a_ctl(0), 32'h15D);
        wait_end(0, 20, got);
        check("R8 head never fires", 64'(got), 64'hFFFF_FFFF_FFFF_FFFF);
        rd(a_ctl(0), d);
        check("R8 head idle", {32'h0, d}, 64'h15D);

        // R7: keepalive chain, R10: watchdog output
        wr(A_SEL, 32'h2);
        wr(a_ctl(0), 0); wr(a_lo(0), 0); wr(a_hi(0), 0);
        wr(a_ctl(2), 0); wr(a_lo(2), 32'd5); wr(a_hi(2), 0);
        wr(a_ctl(2), 32'h13D);
        wr(a_ctl(1), 0); wr(a_lo(1), 32'd10); wr(a_hi(1), 0);
        wr(a_ctl(1), 32'h15D);
        rd(a_ctl(1), d);
        check("R7 idle after enable", {32'h0, d}, 64'h15D);
        wr(a_ctl(0), 32'h1);
        begin
            bit seen1 = 1'b0;
            for (int it = 0; it < 6; it++) begin
                @(negedge clk); seen1 |= end_pulse_o[1];
                @(negedge clk); seen1 |= end_pulse_o[1];
                wr(a_ctl(0), 0);
                seen1 |= end_pulse_o[1];
                wr(a_ctl(0), 32'h1);
                seen1 |= end_pulse_o[1];
            end
            check("R7 keepalive holds off", {63'h0, seen1}, 64'h0);
            check("R10 no reset while alive", {63'h0, wdog_rst_o}, 64'h0);
        end
        wait_end(1, 40, got);
        check("R7 expiry after last ping", 64'(got), 64'd13);
        check("R10 not yet set", {63'h0, wdog_rst_o}, 64'h0);
        @(negedge clk);
        check("R10 set after pulse", {63'h0, wdog_rst_o}, 64'h1);
        idle(5);
        check("R10 sticky", {63'h0, wdog_rst_o}, 64'h1);
        rd(a_ctl(2), d);
        check("R8 other trigger code idle", {32'h0, d}, 64'h13D);
        rd(a_lo(1), d);
        check("R6 expired value", {32'h0, d}, 64'h0);

        // R11: reset clears the request and registers
        do_reset();
        check("R11 wdog cleared", {63'h0, wdog_rst_o}, 64'h0);
        rd(a_ctl(1), d); check("R11 ctrl cleared", {32'h0, d}, 64'h0);
        rd(a_lo(1), d);  check("R11 count cleared", {32'h0, d}, 64'h0);
        rd(A_SEL, d);    check("R11 sel cleared", {32'h0, d}, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule